// File: doc/BRIEF.md
# ARINC 429 Queued Word Transmitter

This block accepts 32-bit words from a host into a 32-entry first-in first-out store. It sends them one at a time as an ARINC 429 serial stream on two logic-level lines. One line pulses for a ONE bit and the other pulses for a ZERO bit. An external line driver turns the two lines into the bipolar bus signal. The bit rate comes from a rate-enable pulse that runs at 10 times the bit rate in high-speed mode and at 80 times the bit rate in low-speed mode. Each bit cell drives its line for the first half of the cell and leaves both lines low for the second half. Consecutive words are separated by a fixed gap.

The host can raise a hold input to preload the queue. While hold is high, no new word starts. When hold is released, the queued words go out back to back, each followed by the gap. The top bit of every word is replaced by a generated parity bit. This bit gives odd parity by default. A control input forces even parity so that receivers can be tested with faulty words. The block exports an empty flag for the queue and a sticky flag that records any dropped write.

Top module: `a429_word_tx`

## Requirements
- R1: Words are sent in the order they were written. Word bit 0 goes out first and word bit 31 goes out last, 32 bit cells per word.
- R2: With `even_par` low, the last bit sent is the inverted XOR of word bits 0..30, so the 32 sent bits hold an odd number of ones. Host bit 31 is discarded.
- R3: With `even_par` high at the moment a word starts, the last bit sent is the XOR of word bits 0..30 (even parity).
- R4: A 1 bit is sent as a high pulse on `line_one` and a 0 bit as a high pulse on `line_zero`. The two lines are never high in the same cycle, and both are low at all other times.
- R5: With `low_speed` low and `rate_en` high every cycle, a bit cell is 10 cycles: the line is high for 5 cycles and then low for 5 cycles.
- R6: With `low_speed` high and `rate_en` high every cycle, a bit cell is 80 cycles: the line is high for 40 cycles and then low for 40 cycles.
- R7: Between two words sent back to back, both lines stay low for exactly 4 bit cells after the last bit cell of the first word. With `rate_en` high every cycle, the low time from the end of the last pulse to the next pulse is 45 cycles at high speed and 360 cycles at low speed.
- R8: While `hold_tx` is high, no new word starts and queued words stay stored. A word already in progress is sent to its end.
- R9: `fifo_empty` is 1 when no word is stored. It goes to 0 in the cycle after a write is accepted.
- R10: A write while 32 words are stored is dropped and sets `wr_overflow`. The flag stays set until reset. The 32 stored words are unaffected.
- R11: After reset, both lines are low, `fifo_empty` is 1 and `wr_overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_en | input | 1 | Rate pulse, 10x (high speed) or 80x (low speed) the bit rate |
| low_speed | input | 1 | 1 selects 80 rate pulses per bit, 0 selects 10 |
| hold_tx | input | 1 | 1 holds new words in the queue |
| even_par | input | 1 | 1 forces even parity on words that start while it is set |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host word, bit 0 sent first |
| line_one | output | 1 | High during the first half of a 1 bit cell |
| line_zero | output | 1 | High during the first half of a 0 bit cell |
| fifo_empty | output | 1 | No word stored |
| wr_overflow | output | 1 | Sticky: a write was dropped because the queue was full |

## Verification
The bench decodes the two lines back into words and measures every pulse and every low interval. This lets it check bit order, parity and cell timing together.

The main path is exercised with several kinds of words:
- Directed parity corners (all zeros, bits 0..30 set, every bit set) show whether host bit 31 is really replaced.
- Random words under odd and even parity separate the two parity senses.
- Runs with a gated, random rate pulse show that bit order does not depend on cycle-exact timing.
- Full-rate runs at both speeds pin down the 5/5 and 40/40 pulse shapes and the 4-cell gap.

Preloading under hold, dropping hold in the middle of a word, and a 33-word burst separate correct queue ordering, hold and overflow behaviour from off-by-one depth or start faults.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_BIT  = 2'd1,
      TX_GAP  = 2'd2
   } tx_state_e;

   // parity bit for the top position, computed over the lower bits
   function automatic logic parity_bit(input logic [30:0] payload, input logic force_even);
      logic x;
      x = ^payload;
      return force_even ? x : ~x;
   endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_pop,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          accept;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign accept  = wr_en && !full;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (accept) wptr <= wptr + 1'b1;
         if (rd_pop) rptr <= rptr + 1'b1;
         case ({accept, rd_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   p_pop_has_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> !empty);
   p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> !empty);
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_pop) |=> (count == $past(count)));
   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

// File: rtl/a429_tx_cell_timer.sv
module a429_tx_cell_timer #(
   parameter int HS_DIV = 10,
   parameter int LS_DIV = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_en,
   input  logic low_speed,
   input  logic restart,
   output logic first_half,
   output logic cell_end
);
   localparam int MAXDIV = (LS_DIV > HS_DIV) ? LS_DIV : HS_DIV;
   localparam int CNT_W  = $clog2(MAXDIV);

   logic [CNT_W-1:0] cnt, last_cnt, half_cnt;

   assign last_cnt   = low_speed ? CNT_W'(LS_DIV - 1) : CNT_W'(HS_DIV - 1);
   assign half_cnt   = low_speed ? CNT_W'(LS_DIV / 2) : CNT_W'(HS_DIV / 2);
   assign cell_end   = rate_en && (cnt >= last_cnt);
   assign first_half = (cnt < half_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n || restart || cell_end) cnt <= '0;
      else if (rate_en)                   cnt <= cnt + 1'b1;
   end

   p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(MAXDIV));
endmodule

// File: rtl/a429_tx_engine.sv
module a429_tx_engine
   import a429_tx_pkg::*;
#(
   parameter int W        = 32,
   parameter int GAP_BITS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_tx,
   input  logic         even_par,
   input  logic         q_empty,
   input  logic [W-1:0] q_data,
   input  logic         first_half,
   input  logic         cell_end,
   output logic         q_pop,
   output logic         restart,
   output logic         line_one,
   output logic         line_zero
);
   localparam int BW = $clog2(W);
   localparam int GW = $clog2(GAP_BITS + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
   localparam logic [GW-1:0] LAST_GAP = GW'(GAP_BITS - 1);

   tx_state_e     st;
   logic [W-1:0]  sh;
   logic [BW-1:0] bit_cnt;
   logic [GW-1:0] gap_cnt;
   logic          par_q, can_start, load, cur_bit;

   assign can_start = !hold_tx && !q_empty;
   assign load      = can_start &&
                      ((st == TX_IDLE) || (st == TX_GAP && cell_end && gap_cnt == LAST_GAP));
   assign q_pop     = load;
   assign restart   = load;
   assign cur_bit   = (bit_cnt == LAST_BIT) ? par_q : sh[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TX_IDLE;
         sh      <= '0;
         bit_cnt <= '0;
         gap_cnt <= '0;
         par_q   <= 1'b0;
      end else if (load) begin
         st      <= TX_BIT;
         sh      <= q_data;
         par_q   <= parity_bit(q_data[W-2:0], even_par);
         bit_cnt <= '0;
      end else begin
         case (st)
            TX_BIT: if (cell_end) begin
               if (bit_cnt == LAST_BIT) begin
                  st      <= TX_GAP;
                  gap_cnt <= '0;
               end else begin
                  sh      <= sh >> 1;
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            TX_GAP: if (cell_end) begin
               if (gap_cnt == LAST_GAP) st <= TX_IDLE;
               else                     gap_cnt <= gap_cnt + 1'b1;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_one  <= 1'b0;
         line_zero <= 1'b0;
      end else begin
         line_one  <= (st == TX_BIT) && first_half &&  cur_bit;
         line_zero <= (st == TX_BIT) && first_half && !cur_bit;
      end
   end

   p_hold_blocks_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_tx && st == TX_IDLE) |=> (st == TX_IDLE));
   p_gap_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_BIT && cell_end && bit_cnt == LAST_BIT && !load) |=> (st == TX_GAP));
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx #(
   parameter int W        = 32,
   parameter int DEPTH    = 32,
   parameter int HS_DIV   = 10,
   parameter int LS_DIV   = 80,
   parameter int GAP_BITS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rate_en,
   input  logic         low_speed,
   input  logic         hold_tx,
   input  logic         even_par,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         line_one,
   output logic         line_zero,
   output logic         fifo_empty,
   output logic         wr_overflow
);
   generate
      if (W != 32) begin : g_bad_width
         $error("word width must be 32");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (HS_DIV < 2 || LS_DIV < 2 || (HS_DIV % 2) != 0 || (LS_DIV % 2) != 0) begin : g_bad_div
         $error("rate dividers must be even and at least 2");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("GAP_BITS must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_data;
   logic         q_pop, q_full, restart, first_half, cell_end;

   a429_tx_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_pop(q_pop), .rd_data(q_data), .empty(fifo_empty),
      .full(q_full), .ovf(wr_overflow)
   );

   a429_tx_cell_timer #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) i_timer (
      .clk(clk), .rst_n(rst_n), .rate_en(rate_en), .low_speed(low_speed),
      .restart(restart), .first_half(first_half), .cell_end(cell_end)
   );

   a429_tx_engine #(.W(W), .GAP_BITS(GAP_BITS)) i_engine (
      .clk(clk), .rst_n(rst_n), .hold_tx(hold_tx), .even_par(even_par),
      .q_empty(fifo_empty), .q_data(q_data), .first_half(first_half),
      .cell_end(cell_end), .q_pop(q_pop), .restart(restart),
      .line_one(line_one), .line_zero(line_zero)
   );

   p_lines_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_one && line_zero));
   p_full_not_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !fifo_empty);
endmodule

// File: tb/test_a429_word_tx.sv
module test_a429_word_tx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_en = 1'b1, low_speed = 1'b0, hold_tx = 1'b0, even_par = 1'b0;
   logic wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic line_one, line_zero, fifo_empty, wr_overflow;

   always #5 clk = ~clk;

   a429_word_tx i_a429_word_tx (
      .clk(clk), .rst_n(rst_n), .rate_en(rate_en), .low_speed(low_speed),
      .hold_tx(hold_tx), .even_par(even_par), .wr_en(wr_en), .wr_data(wr_data),
      .line_one(line_one), .line_zero(line_zero), .fifo_empty(fifo_empty),
      .wr_overflow(wr_overflow)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // expected words and decoded words
   logic [31:0] exp_w [128];
   int          exp_n = 0;
   logic [31:0] rx_w [128];
   bit          rx_bad [128];
   int          rx_gap [128];
   int          rx_n = 0;

   // monitor state
   int  prev_lvl = 0, run = 0, bits = 0, last_gap = 0, half = 5;
   bit  exact = 1, width_bad = 0, rand_rate = 0;
   logic [31:0] cur = '0;

   function automatic logic [31:0] exp_word(input logic [31:0] d, input logic ev);
      logic p;
      p = ^d[30:0];
      return {ev ? p : ~p, d[30:0]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      int lvl;
      if (rst_n) begin
         if (line_one && line_zero) check(0, "R4 both lines high", 64'd3, 64'd0);
         lvl = line_one ? 1 : (line_zero ? 2 : 0);
         if (lvl != prev_lvl) begin
            if (prev_lvl != 0 && lvl == 0) begin
               cur[bits] = (prev_lvl == 1);
               if (exact && run != half) width_bad = 1;
               bits++;
               if (bits == 32) begin
                  rx_w[rx_n] = cur; rx_bad[rx_n] = width_bad; rx_gap[rx_n] = last_gap;
                  rx_n++; bits = 0; width_bad = 0;
               end
            end else if (prev_lvl == 0 && lvl != 0) begin
               if (bits == 0) last_gap = run;
               else if (exact && run != half) width_bad = 1;
            end
            run = 1;
         end else run++;
         prev_lvl = lvl;
      end
   end

   always @(negedge clk) rate_en <= rand_rate ? 1'($urandom % 2) : 1'b1;

   task automatic put(input logic [31:0] d, input bit keep);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      if (keep) begin exp_w[exp_n] = exp_word(d, even_par); exp_n++; end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      int t = 0;
      while (rx_n < n && t < 40000) begin @(negedge clk); t++; end
   endtask

   task automatic check_words(input int from, input int to, input string req, input bit widths);
      for (int i = from; i < to; i++) begin
         check(rx_w[i] === exp_w[i], req, {32'd0, rx_w[i]}, {32'd0, exp_w[i]});
         if (widths) check(!rx_bad[i], "R5/R6 pulse or cell width", 64'(rx_bad[i]), 64'd0);
      end
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      void'($urandom(32'd429));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!line_one && !line_zero, "R11 lines low", {62'd0, line_one, line_zero}, 0);
      check(fifo_empty === 1'b1, "R11 empty after reset", 64'(fifo_empty), 1);
      check(wr_overflow === 1'b0, "R11 no overflow after reset", 64'(wr_overflow), 0);

      // R9 / R8: preload under hold
      hold_tx = 1'b1;
      put(32'h8000_00A5, 1);
      check(fifo_empty === 1'b0, "R9 empty drops after write", 64'(fifo_empty), 0);
      repeat (600) @(negedge clk);
      check(rx_n == 0 && bits == 0 && prev_lvl == 0, "R8 nothing sent under hold", 64'(rx_n + bits), 0);
      hold_tx = 1'b0;
      wait_rx(1);
      check_words(0, 1, "R1 R2 single word odd parity", 1);

      // R7 + R2 parity corners back to back
      hold_tx = 1'b1;
      put(32'h0000_0000, 1);
      put(32'h7FFF_FFFF, 1);
      put(32'hFFFF_FFFF, 1);
      hold_tx = 1'b0;
      wait_rx(4);
      check_words(1, 4, "R2 parity corner words", 1);
      check(rx_gap[2] == 45, "R7 high speed gap", 64'(rx_gap[2]), 45);
      check(rx_gap[3] == 45, "R7 high speed gap", 64'(rx_gap[3]), 45);
      repeat (100) @(negedge clk);

      // R3 even parity
      even_par = 1'b1;
      for (int i = 0; i < 3; i++) put($urandom, 1);
      wait_rx(7);
      check_words(4, 7, "R3 even parity", 1);
      even_par = 1'b0;
      repeat (100) @(negedge clk);

      // R6 low speed
      low_speed = 1'b1; half = 40;
      hold_tx = 1'b1;
      put(32'h1234_5678, 1);
      put(32'hCAFE_0F0F, 1);
      hold_tx = 1'b0;
      wait_rx(9);
      check_words(7, 9, "R6 low speed words", 1);
      check(rx_gap[8] == 360, "R7 low speed gap", 64'(rx_gap[8]), 360);
      repeat (800) @(negedge clk);
      low_speed = 1'b0; half = 5;

      // R1 random words with gated rate pulse
      exact = 0; rand_rate = 1;
      for (int i = 0; i < 12; i++) begin
         put($urandom, 1);
         repeat ($urandom % 300) @(negedge clk);
      end
      wait_rx(21);
      check_words(9, 21, "R1 random words, gated rate", 0);
      repeat (200) @(negedge clk);
      rand_rate = 0; exact = 1;
      repeat (50) @(negedge clk);

      // R8 hold raised mid word
      put(32'h0F0F_1234, 1);
      put(32'hA5A5_5A5A, 1);
      while (bits < 3) @(negedge clk);
      hold_tx = 1'b1;
      wait_rx(22);
      repeat (1000) @(negedge clk);
      check(rx_n == 22, "R8 in-progress word completes, next held", 64'(rx_n), 22);
      check(fifo_empty === 1'b0, "R8 held word stays queued", 64'(fifo_empty), 0);
      hold_tx = 1'b0;
      wait_rx(23);
      check_words(21, 23, "R8 words after release", 1);
      repeat (100) @(negedge clk);

      // R10 overflow
      hold_tx = 1'b1;
      base = rx_n;
      for (int i = 0; i < 32; i++) put($urandom, 1);
      check(wr_overflow === 1'b0, "R10 no overflow at 32 words", 64'(wr_overflow), 0);
      put(32'hDEAD_BEEF, 0);
      check(wr_overflow === 1'b1, "R10 overflow on 33rd write", 64'(wr_overflow), 1);
      hold_tx = 1'b0;
      wait_rx(base + 32);
      repeat (600) @(negedge clk);
      check_words(base, base + 32, "R10 stored words intact", 1);
      check(rx_n == base + 32, "R10 dropped word not sent", 64'(rx_n), 64'(base + 32));
      check(fifo_empty === 1'b1, "R9 empty after drain", 64'(fifo_empty), 1);
      check(wr_overflow === 1'b1, "R10 overflow sticky", 64'(wr_overflow), 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule